// File: doc/BRIEF.md
# Per-Channel Event Capture Buffer with Gray Timestamp

This block captures digitised hit events for one detector channel and holds them until a readout engine collects them. A free-running coarse timestamp counter advances once per bunch-crossing clock and presents its value in Gray code. When the front end raises its event strobe, the block builds one 38-bit event word and writes it into a small first-in first-out store. The word holds a hit flag, a threshold bit, the channel number, the amplitude code, the fine-time code and the coarse timestamp sampled on that same edge. The fine time is measured relative to the bunch-crossing clock, so the 8-bit fine code and the 12-bit coarse count together form a 20-bit time tag.

The readout side removes words through a valid/ready handshake. The store holds at most four words. Once it is full, further strobes are discarded and a sticky overflow flag records that a burst was cut short. Words already stored are not disturbed. Occupancy and a full indication are available as outputs.

The store is run by a three-state controller. `ST_EMPTY` holds no word. `ST_PARTIAL` holds between one and DEPTH-1 words. `ST_FULL` holds DEPTH words. The transitions are:
- `fill`: `ST_EMPTY`→`ST_PARTIAL`, or `ST_PARTIAL`→`ST_FULL` on the last free slot.
- `drain`: `ST_FULL`→`ST_PARTIAL`, or `ST_PARTIAL`→`ST_EMPTY` on the last word.
- `swap`: a simultaneous accepted write and read in `ST_PARTIAL`, which keeps the state.

Top module: `chan_event_buf`

## Requirements
- R1: While reset is asserted and right after it is released, `ts_gray` is 0, `rd_valid` is 0, `fifo_full` is 0, `level` is 0 and `overflow` is 0.
- R2: `ts_gray` follows the sequence g(n) = b ^ (b >> 1), with b = n mod 4096 and n the number of rising clock edges since reset was released. After code 12'h800 it wraps to 0.
- R3: Any two successive `ts_gray` values after reset differ in exactly one bit.
- R4: A stored word has this layout: [37] flag, [36] threshold bit, [35:30] channel address, [29:20] amplitude, [19:12] fine time, [11:0] timestamp. The timestamp equals the `ts_gray` value present in the cycle in which `ev_strobe` is sampled high.
- R5: Up to four words are held. They are read out in the order they were written.
- R6: A strobe arriving while `fifo_full` is 1 is discarded. The stored words and `level` are unchanged, and `overflow` becomes 1 on the following cycle.
- R7: `overflow` stays 1 until the next reset.
- R8: `rd_valid` is 1 exactly when `level` is nonzero. While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds steady. A word is removed on an edge where both are 1.
- R9: In the partial state, a strobe and a pop on the same edge both take effect and `level` is unchanged. In the full state, a pop on the same edge as a strobe still discards the strobe, so `level` drops by one.
- R10: `level` reports the number of stored words (0 to 4), and `fifo_full` is 1 exactly when `level` equals 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 1 | Peak-found strobe; one event per high cycle |
| ev_flag | input | 1 | Hit flag of the event |
| ev_thr | input | 1 | Threshold-crossing bit of the event |
| ev_addr | input | 6 | Channel number |
| ev_amp | input | 10 | Amplitude code |
| ev_ftime | input | 8 | Fine-time code relative to the clock |
| rd_ready | input | 1 | Readout accepts the head word |
| rd_valid | output | 1 | A word is available |
| rd_data | output | 38 | Head event word |
| ts_gray | output | 12 | Coarse timestamp in Gray code |
| level | output | 3 | Number of stored words |
| fifo_full | output | 1 | Store holds DEPTH words |
| overflow | output | 1 | Sticky: an event was discarded |

## Verification
The bench builds the block with its default DEPTH of 4 and the fixed 12-bit timestamp. That configuration is small enough to walk the counter through all 4096 codes and past the wrap, comparing each code with one computed arithmetically from the edge count. Four slots let a short burst drive the controller through every state and transition, including overflow during a burst, a combined write and read in `ST_PARTIAL`, and a write that collides with a read in `ST_FULL`. Event fields come from arithmetic patterns, so every field position gets distinct nonzero values.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
    localparam int TS_W   = 12;
    localparam int ADDR_W = 6;
    localparam int AMP_W  = 10;
    localparam int FT_W   = 8;

    typedef struct packed {
        logic              flag;
        logic              thr;
        logic [ADDR_W-1:0] addr;
        logic [AMP_W-1:0]  amp;
        logic [FT_W-1:0]   ftime;
        logic [TS_W-1:0]   ts;
    } event_word_t;

    localparam int EVW_W = $bits(event_word_t);

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;
endpackage

// File: rtl/gray_ts_counter.sv
module gray_ts_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] gray
);
    logic [W-1:0] bin_q;

    always_ff @(posedge clk) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_q + 1'b1;
    end

    // The code is derived from a registered binary count, so only one bit toggles per step
    assign gray = bin_q ^ (bin_q >> 1);
endmodule

// File: rtl/event_fifo.sv
module event_fifo
    import evbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_req,
    input  event_word_t din,
    input  logic        pop_req,
    output event_word_t dout,
    output logic        not_empty,
    output logic        full,
    output logic [CW-1:0] count
);
    fill_state_t state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    event_word_t   slots [DEPTH];
    logic          push_ok, pop_ok;

    assign push_ok = push_req && (state_q != ST_FULL);
    assign pop_ok  = pop_req  && (state_q != ST_EMPTY);

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state logic: fill / drain / swap
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (push_ok && !pop_ok) count_d = count_q + 1'b1;
        if (pop_ok && !push_ok) count_d = count_q - 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_ok) state_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push_ok && !pop_ok && count_q == CW'(DEPTH - 1))
                    state_d = ST_FULL;
                else if (pop_ok && !push_ok && count_q == CW'(1))
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop_ok) state_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr_q == PW'(i)) slots[i] <= din;
        end
    end

    // outputs
    always_comb begin
        not_empty = (state_q != ST_EMPTY);
        full      = (state_q == ST_FULL);
        count     = count_q;
        dout      = slots[rd_ptr_q];
    end
endmodule

// File: rtl/chan_event_buf.sv
module chan_event_buf
    import evbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_strobe,
    input  logic              ev_flag,
    input  logic              ev_thr,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [AMP_W-1:0]  ev_amp,
    input  logic [FT_W-1:0]   ev_ftime,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [EVW_W-1:0]  rd_data,
    output logic [TS_W-1:0]   ts_gray,
    output logic [CW-1:0]     level,
    output logic              fifo_full,
    output logic              overflow
);
    event_word_t word_in, word_out;
    logic        ovf_q;

    gray_ts_counter #(.W(TS_W)) u_ts (
        .clk  (clk),
        .rst_n(rst_n),
        .gray (ts_gray)
    );

    always_comb begin
        word_in.flag  = ev_flag;
        word_in.thr   = ev_thr;
        word_in.addr  = ev_addr;
        word_in.amp   = ev_amp;
        word_in.ftime = ev_ftime;
        word_in.ts    = ts_gray;
    end

    event_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (ev_strobe),
        .din      (word_in),
        .pop_req  (rd_ready),
        .dout     (word_out),
        .not_empty(rd_valid),
        .full     (fifo_full),
        .count    (level)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (ev_strobe && fifo_full) ovf_q <= 1'b1;
    end

    assign overflow = ovf_q;
    assign rd_data  = word_out;
endmodule

// File: rtl/chan_event_buf_chk.sv
module chan_event_buf_chk #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_strobe,
    input logic          rd_ready,
    input logic          rd_valid,
    input logic [37:0]   rd_data,
    input logic [11:0]   ts_gray,
    input logic [CW-1:0] level,
    input logic          fifo_full,
    input logic          overflow
);
    // R3: one bit changes per step once two reset-free edges are seen
    assert_gray_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(ts_gray ^ $past(ts_gray)) == 1);

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && ev_strobe && !rd_ready) |=> ($stable(level) && overflow));

    assert_hold_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !fifo_full) |=> $stable(rd_data) || !rd_valid);

    assert_valid_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (level != '0));

    assert_swap_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !fifo_full && ev_strobe && rd_ready) |=> $stable(level));
endmodule

bind chan_event_buf chan_event_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_strobe(ev_strobe),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .ts_gray  (ts_gray),
    .level    (level),
    .fifo_full(fifo_full),
    .overflow (overflow)
);

// File: tb/sim_chan_event_buf.sv
module sim_chan_event_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_strobe = 1'b0, ev_flag = 1'b0, ev_thr = 1'b0;
    logic [5:0]  ev_addr = '0;
    logic [9:0]  ev_amp = '0;
    logic [7:0]  ev_ftime = '0;
    logic        rd_ready = 1'b0;
    logic        rd_valid, fifo_full, overflow;
    logic [37:0] rd_data;
    logic [11:0] ts_gray;
    logic [2:0]  level;

    int n_checks = 0;
    int n_fail   = 0;
    logic [37:0] expq[$];

    always #4 clk = ~clk;

    chan_event_buf u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] g12(input int n);
        logic [11:0] b = 12'(n % 4096);
        return b ^ (b >> 1);
    endfunction

    // drive one event at a negedge; optionally pop in the same cycle
    task automatic send(input int k, input bit also_pop, input bit expect_keep);
        ev_strobe = 1'b1;
        ev_flag   = k[0];
        ev_thr    = ~k[1];
        ev_addr   = 6'(k * 13 + 5);
        ev_amp    = 10'(k * 97 + 3);
        ev_ftime  = 8'(k * 29 + 1);
        rd_ready  = also_pop;
        if (expect_keep)
            expq.push_back({ev_flag, ev_thr, ev_addr, ev_amp, ev_ftime, ts_gray});
        @(negedge clk);
        ev_strobe = 1'b0;
        rd_ready  = 1'b0;
    endtask

    task automatic pop_check(input string req);
        logic [37:0] e = expq.pop_front();
        chk(rd_valid === 1'b1, "R8", "rd_valid before pop", 64'(rd_valid), 1);
        chk(rd_data === e, req, "head word", 64'(rd_data), 64'(e));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int bad_seq, bad_step;
        logic [11:0] prev, first_bad;
        logic [37:0] head;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ts_gray === 12'd0 && level === 3'd0, "R1", "ts/level in reset",
            64'({ts_gray, level}), 0);
        rst_n = 1'b1;
        chk(ts_gray === 12'd0, "R1", "ts after release", 64'(ts_gray), 0);
        chk(!rd_valid && !fifo_full && !overflow, "R1", "flags after release",
            64'({rd_valid, fifo_full, overflow}), 0);

        // full sweep of the counter through the wrap
        bad_seq = 0; bad_step = 0; first_bad = '0; prev = ts_gray;
        for (int n = 0; n <= 4100; n++) begin
            if (ts_gray !== g12(n)) begin
                if (bad_seq == 0) first_bad = ts_gray;
                bad_seq++;
            end
            if (n > 0 && $countones(ts_gray ^ prev) != 1) bad_step++;
            if (n == 4096)
                chk(ts_gray === 12'd0 && prev === 12'h800, "R2", "wrap to zero",
                    64'({prev, ts_gray}), 64'({12'h800, 12'h000}));
            prev = ts_gray;
            @(negedge clk);
        end
        chk(bad_seq == 0, "R2", "gray sequence mismatches", 64'(first_bad), 0);
        chk(bad_step == 0, "R3", "multi-bit steps", 64'(bad_step), 0);

        // single event through the store
        send(1, 1'b0, 1'b1);
        chk(level === 3'd1, "R10", "level after one", 64'(level), 1);
        head = expq[0];
        chk(rd_data[35:30] === head[35:30] && rd_data[11:0] === head[11:0], "R4",
            "address and timestamp fields", 64'(rd_data), 64'(head));
        pop_check("R4");
        chk(!rd_valid && level === 3'd0, "R8", "empty after pop",
            64'({rd_valid, level}), 0);

        // burst of six: four kept, two dropped
        for (int k = 2; k < 6; k++) begin
            send(k, 1'b0, 1'b1);
            chk(level === 3'(k - 1), "R10", "level during fill", 64'(level), 64'(k - 1));
            chk(rd_data === expq[0], "R8", "head stable while not ready",
                64'(rd_data), 64'(expq[0]));
        end
        chk(fifo_full === 1'b1 && overflow === 1'b0, "R10", "full, no overflow yet",
            64'({fifo_full, overflow}), 64'(2'b10));
        send(6, 1'b0, 1'b0);
        chk(overflow === 1'b1 && level === 3'd4, "R6", "drop sets overflow",
            64'({overflow, level}), 64'({1'b1, 3'd4}));
        send(7, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) pop_check("R5");
        chk(!rd_valid && overflow === 1'b1, "R7", "overflow remains after drain",
            64'({rd_valid, overflow}), 1);

        // combined write and read in the partial state
        send(8, 1'b0, 1'b1);
        send(9, 1'b0, 1'b1);
        head = expq.pop_front();
        chk(rd_data === head, "R9", "head before swap", 64'(rd_data), 64'(head));
        send(10, 1'b1, 1'b1);
        chk(level === 3'd2, "R9", "level kept by swap", 64'(level), 2);
        pop_check("R9");
        pop_check("R9");

        // strobe colliding with a pop while full
        for (int k = 11; k < 15; k++) send(k, 1'b0, 1'b1);
        head = expq.pop_front();
        chk(rd_data === head, "R9", "head before full collision", 64'(rd_data), 64'(head));
        send(15, 1'b1, 1'b0);
        chk(level === 3'd3 && !fifo_full, "R9", "full collision drops write",
            64'({fifo_full, level}), 3);
        for (int k = 0; k < 3; k++) pop_check("R9");

        // overflow clears only on reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(overflow === 1'b0 && level === 3'd0 && ts_gray === 12'd0, "R7",
            "reset clears overflow", 64'({overflow, level, ts_gray}), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule